// File: doc/BRIEF.md
# Table Pointer Transfer Unit

This block moves single bytes between program memory and an 8-bit holding latch. The program-memory location is named by a 21-bit pointer. The instruction sequencer presents an opcode together with a valid strobe. When the opcode is one of the eight table-access codes, the unit does three things:

- It issues one byte request on a synchronous program-memory port.
- On a read, it captures the returned byte into the latch. On a write, it sends the latch contents to memory.
- It adjusts the pointer as the opcode's two low bits direct.

Every accepted access is held for two clock cycles. During both cycles a busy flag tells the sequencer to insert the extra stall.

The pointer and the latch can also be loaded directly from the surrounding datapath when the unit is idle. These loads model the ordinary register writes that set up a transfer. The memory port is synchronous: a read request issued in one cycle returns its byte in the next cycle.

Top module: `tblx_unit`

## Requirements
- R1: After synchronous reset, the following are all 0: busy, mem_req, mem_we, the pointer and the latch.
- R2: Only opcodes 16'h0008 to 16'h000B (reads) and 16'h000C to 16'h000F (writes) start an access. Bit 2 = 1 marks a write. Any other opcode is ignored: busy and mem_req stay low and the pointer and latch keep their values.
- R3: An accepted opcode holds busy high for exactly two cycles. mem_req is high only in the first of those two cycles.
- R4: For a read, mem_we stays 0. The byte returned on mem_rdata in the second busy cycle is held in the latch once busy falls.
- R5: For a write, the request cycle carries mem_we = 1 and mem_wdata = the latch value. The latch does not change.
- R6: Opcode bits [1:0] = 00 leave the pointer unchanged, and the request address is the pointer.
- R7: Bits [1:0] = 01 (post-increment) and 10 (post-decrement) address memory with the old pointer. The pointer stays unchanged through both busy cycles and shows the value plus or minus 1 once busy falls.
- R8: Bits [1:0] = 11 (pre-increment) add 1 to the pointer before the access. Both the request address and the pointer output equal the old pointer plus 1 from the first busy cycle on.
- R9: Pointer arithmetic wraps modulo 2^21. Incrementing 21'h1FFFFF gives 0, and decrementing 0 gives 21'h1FFFFF.
- R10: While busy, new opcodes and both direct loads are ignored.
- R11: When idle, ptr_load and latch_load set the pointer and latch one cycle later. If a table opcode starts in the same cycle, the opcode wins and the loads are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode on op_code is being issued this cycle |
| op_code | input | 16 | Instruction word |
| ptr_load | input | 1 | Load the pointer from ptr_load_val |
| ptr_load_val | input | 21 | Pointer load value |
| latch_load | input | 1 | Load the latch from latch_load_val |
| latch_load_val | input | 8 | Latch load value |
| mem_rdata | input | 8 | Program-memory read byte, valid the cycle after the request |
| busy | output | 1 | Access in progress; the sequencer stalls |
| ptr_q | output | 21 | Current pointer |
| latch_q | output | 8 | Current latch contents |
| mem_req | output | 1 | Program-memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 21 | Request address |
| mem_wdata | output | 8 | Write byte |

## Verification
The bench runs all sixteen low opcodes, plus opcodes that differ from the table codes only in upper bits, against pointers that sit on both ends of the 21-bit range. A design that decoded only the low nibble would start accesses on those near-miss codes. Wrong wrap handling would show up at 21'h1FFFFF and at 0. Applying an increment on the wrong side of the access would send the old address for pre-increment, or change the pointer during the busy window for the post modes. Opcodes and loads driven during both busy cycles, and a load that collides with an opcode start, would corrupt the pointer or the latch if the busy or precedence gating were missing.

// File: rtl/tblx_pkg.sv
package tblx_pkg;

    localparam int OPC_W = 16;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'b00,
        MODE_POSTINC = 2'b01,
        MODE_POSTDEC = 2'b10,
        MODE_PREINC  = 2'b11
    } ptr_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_ACCESS = 2'b01,
        PH_FINISH = 2'b10
    } phase_e;

    typedef struct packed {
        logic      hit;
        logic      is_write;
        ptr_mode_e mode;
    } tbl_op_t;

    // Table codes are 0x0008..0x000F: all upper bits zero, bit 3 set.
    function automatic tbl_op_t decode_op(input logic [OPC_W-1:0] code);
        tbl_op_t r;
        r.hit      = (code[OPC_W-1:3] == {{(OPC_W-4){1'b0}}, 1'b1});
        r.is_write = code[2];
        r.mode     = ptr_mode_e'(code[1:0]);
        return r;
    endfunction

endpackage

// File: rtl/tblx_seq.sv
module tblx_seq
    import tblx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_req,
    input  tbl_op_t   dec,
    output phase_e    phase,
    output logic      accept,
    output logic      cur_write,
    output ptr_mode_e cur_mode
);

    phase_e phase_q;
    phase_e phase_d;

    assign accept = (phase_q == PH_IDLE) && start_req;
    assign phase  = phase_q;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start_req) phase_d = PH_ACCESS;
            PH_ACCESS: phase_d = PH_FINISH;
            PH_FINISH: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cur_write <= 1'b0;
            cur_mode  <= MODE_HOLD;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                cur_write <= dec.is_write;
                cur_mode  <= dec.mode;
            end
        end
    end

    // R3: the access cycle is always followed by the finishing cycle
    p_access_then_finish_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACCESS) |=> (phase_q == PH_FINISH));

    // R3: the finishing cycle always returns to idle
    p_finish_then_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FINISH) |=> (phase_q == PH_IDLE));

    // R10: the captured operation does not change while busy
    p_op_held_r10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACCESS) |=> ($stable(cur_write) && $stable(cur_mode)));

endmodule

// File: rtl/tblx_ptr.sv
module tblx_ptr
    import tblx_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  ptr_mode_e        new_mode,
    input  logic             in_access,
    input  logic             finish,
    input  ptr_mode_e        cur_mode,
    input  logic             load_en,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] ptr_q
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (accept) begin
            if (new_mode == MODE_PREINC) ptr_d = ptr_q + ONE;
        end else if (finish) begin
            unique case (cur_mode)
                MODE_POSTINC: ptr_d = ptr_q + ONE;
                MODE_POSTDEC: ptr_d = ptr_q - ONE;
                default:      ptr_d = ptr_q;
            endcase
        end else if (load_en) begin
            ptr_d = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    // R8: pre-increment takes effect at the accepting edge, modulo 2^PTR_W (R9)
    p_preinc_early_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && new_mode == MODE_PREINC) |=> (ptr_q == $past(ptr_q) + ONE));

    // R7: no pointer movement between the request cycle and the finishing cycle
    p_hold_in_access_r7: assert property (@(posedge clk) disable iff (rst)
        in_access |=> $stable(ptr_q));

    // R6: hold mode never moves the pointer at completion
    p_hold_mode_r6: assert property (@(posedge clk) disable iff (rst)
        (finish && cur_mode == MODE_HOLD) |=> $stable(ptr_q));

endmodule

// File: rtl/tblx_latch.sv
module tblx_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] latch_q
);

    always_ff @(posedge clk) begin
        if (rst)          latch_q <= '0;
        else if (rd_done) latch_q <= rd_data;
        else if (load_en) latch_q <= load_val;
    end

    // R4: a completed read leaves the returned byte in the latch
    p_read_capture_r4: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> (latch_q == $past(rd_data)));

endmodule

// File: rtl/tblx_unit.sv
module tblx_unit
    import tblx_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [15:0]       op_code,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_load_val,
    input  logic              latch_load,
    input  logic [DATA_W-1:0] latch_load_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [DATA_W-1:0] latch_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    tbl_op_t   dec;
    phase_e    phase;
    logic      accept;
    logic      cur_write;
    ptr_mode_e cur_mode;
    logic      idle_load_ok;
    logic      finish;

    assign dec = decode_op(op_code);

    tblx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (op_valid && dec.hit),
        .dec       (dec),
        .phase     (phase),
        .accept    (accept),
        .cur_write (cur_write),
        .cur_mode  (cur_mode)
    );

    assign busy         = (phase != PH_IDLE);
    assign finish       = (phase == PH_FINISH);
    assign idle_load_ok = !busy && !accept;

    tblx_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .new_mode  (dec.mode),
        .in_access (phase == PH_ACCESS),
        .finish    (finish),
        .cur_mode  (cur_mode),
        .load_en   (ptr_load && idle_load_ok),
        .load_val  (ptr_load_val),
        .ptr_q     (ptr_q)
    );

    tblx_latch #(.DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .rd_done  (finish && !cur_write),
        .rd_data  (mem_rdata),
        .load_en  (latch_load && idle_load_ok),
        .load_val (latch_load_val),
        .latch_q  (latch_q)
    );

    assign mem_req   = (phase == PH_ACCESS);
    assign mem_we    = mem_req && cur_write;
    assign mem_addr  = ptr_q;
    assign mem_wdata = latch_q;

    // R2: no memory traffic while idle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R3: a request is followed by a busy cycle without a request
    p_req_single_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> (busy && !mem_req));

    // R5: a write never disturbs the latch through the end of the access
    p_write_keeps_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> $stable(latch_q));

endmodule

// File: tb/tblx_unit_bench.sv
`timescale 1ns/1ps
module tblx_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] op_code = '0;
    logic        ptr_load = 1'b0;
    logic [20:0] ptr_load_val = '0;
    logic        latch_load = 1'b0;
    logic [7:0]  latch_load_val = '0;
    logic [7:0]  mem_rdata = '0;
    logic        busy, mem_req, mem_we;
    logic [20:0] ptr_q, mem_addr;
    logic [7:0]  latch_q, mem_wdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tblx_unit u_tblx_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
        .latch_load(latch_load), .latch_load_val(latch_load_val),
        .mem_rdata(mem_rdata), .busy(busy), .ptr_q(ptr_q), .latch_q(latch_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] mem_byte(input logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
    endfunction

    int          wr_count = 0;
    logic [20:0] wr_addr_seen = '0;
    logic [7:0]  wr_data_seen = '0;

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem_byte(mem_addr);
        if (mem_req && mem_we) begin
            wr_count     <= wr_count + 1;
            wr_addr_seen <= mem_addr;
            wr_data_seen <= mem_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_both(input logic [20:0] p, input logic [7:0] l);
        @(negedge clk);
        ptr_load = 1'b1; ptr_load_val = p;
        latch_load = 1'b1; latch_load_val = l;
        @(negedge clk);
        ptr_load = 1'b0; latch_load = 1'b0;
        chk("R11 pointer load", 32'(ptr_q), 32'(p));
        chk("R11 latch load", 32'(latch_q), 32'(l));
    endtask

    // Issue one opcode; disturb=1 drives opcodes and loads during both busy cycles.
    task automatic run_op(input logic [15:0] code, input logic [20:0] p,
                          input logic [7:0] l, input bit disturb, input bit collide);
        logic        hit;
        logic        wr;
        logic [1:0]  md;
        logic [20:0] exp_addr, exp_ptr;
        logic [7:0]  exp_latch;
        int          wc0;
        hit = (code[15:3] == 13'h0001);
        wr  = code[2];
        md  = code[1:0];
        exp_addr  = (md == 2'b11) ? p + 21'd1 : p;
        exp_ptr   = (md == 2'b01 || md == 2'b11) ? p + 21'd1 :
                    (md == 2'b10) ? p - 21'd1 : p;
        exp_latch = wr ? l : mem_byte(exp_addr);
        load_both(p, l);
        wc0 = wr_count;
        @(negedge clk);
        op_valid = 1'b1; op_code = code;
        if (collide) begin
            ptr_load = 1'b1; ptr_load_val = 21'h0F0F0;
            latch_load = 1'b1; latch_load_val = 8'hC3;
        end
        @(negedge clk);
        op_valid = 1'b0; ptr_load = 1'b0; latch_load = 1'b0;
        if (!hit) begin
            chk("R2 no busy on foreign opcode", 32'(busy), 0);
            chk("R2 no request on foreign opcode", 32'(mem_req), 0);
            @(negedge clk);
            chk("R2 pointer untouched", 32'(ptr_q), 32'(p));
            chk("R2 latch untouched", 32'(latch_q), 32'(l));
            return;
        end
        chk("R3 busy first cycle", 32'(busy), 1);
        chk("R3 request first cycle", 32'(mem_req), 1);
        chk(wr ? "R5 write strobe" : "R4 read strobe", 32'(mem_we), 32'(wr));
        if (md == 2'b11)      chk("R8 preinc address", 32'(mem_addr), 32'(exp_addr));
        else if (md == 2'b00) chk("R6 hold address", 32'(mem_addr), 32'(exp_addr));
        else                  chk("R7 post address", 32'(mem_addr), 32'(exp_addr));
        if (md == 2'b11) chk("R8 pointer early", 32'(ptr_q), 32'(exp_addr));
        if (wr) chk("R5 write data", 32'(mem_wdata), 32'(l));
        if (disturb) begin
            op_valid = 1'b1; op_code = 16'h000B;
            ptr_load = 1'b1; ptr_load_val = 21'h12345;
            latch_load = 1'b1; latch_load_val = 8'h77;
        end
        @(negedge clk);
        chk("R3 busy second cycle", 32'(busy), 1);
        chk("R3 no request second cycle", 32'(mem_req), 0);
        if (md == 2'b01 || md == 2'b10)
            chk("R7 pointer unchanged in busy", 32'(ptr_q), 32'(p));
        @(negedge clk);
        op_valid = 1'b0; ptr_load = 1'b0; latch_load = 1'b0;
        chk("R3 busy falls after two cycles", 32'(busy), 0);
        chk(disturb ? "R10 pointer after busy-time inputs" : "R9 final pointer",
            32'(ptr_q), 32'(exp_ptr));
        chk(wr ? "R5 latch kept on write" : "R4 latch captured",
            32'(latch_q), 32'(exp_latch));
        if (wr) begin
            chk("R5 one write issued", 32'(wr_count - wc0), 1);
            chk("R5 write address seen", 32'(wr_addr_seen), 32'(exp_addr));
        end else begin
            chk("R4 no write issued", 32'(wr_count - wc0), 0);
        end
        @(negedge clk);
        chk(disturb ? "R10 no access started while busy" : "R3 stays idle", 32'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [20:0] ptrs [4];
        logic [15:0] others [4];
        ptrs[0] = 21'h000000; ptrs[1] = 21'h1FFFFF;
        ptrs[2] = 21'h0ABCD;  ptrs[3] = 21'h10000F;
        others[0] = 16'h0018; others[1] = 16'h0108;
        others[2] = 16'h800C; others[3] = 16'h0007;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 request", 32'(mem_req), 0);
        chk("R1 write strobe", 32'(mem_we), 0);
        chk("R1 pointer", 32'(ptr_q), 0);
        chk("R1 latch", 32'(latch_q), 0);
        rst = 1'b0;
        for (int pi = 0; pi < 4; pi++) begin
            for (int c = 0; c < 16; c++) begin
                run_op(16'(c), ptrs[pi], 8'(8'h31 + 8'(c) + 8'(pi * 16)), 1'b0, 1'b0);
            end
            for (int k = 0; k < 4; k++) begin
                run_op(others[k], ptrs[pi], 8'h9E, 1'b0, 1'b0);
            end
        end
        // R9 wrap corners
        run_op(16'h0009, 21'h1FFFFF, 8'h01, 1'b0, 1'b0);
        run_op(16'h000A, 21'h000000, 8'h02, 1'b0, 1'b0);
        run_op(16'h000F, 21'h1FFFFF, 8'h03, 1'b0, 1'b0);
        // R10 inputs during busy
        for (int c = 8; c < 16; c++) begin
            run_op(16'(c), 21'h04321, 8'hA5, 1'b1, 1'b0);
        end
        // R11 opcode start has precedence over same-cycle loads
        run_op(16'h0009, 21'h00100, 8'h44, 1'b0, 1'b1);
        run_op(16'h000D, 21'h00200, 8'h55, 1'b0, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule